// File: doc/BRIEF.md
# External Memory Bus Wait-State Controller

This block connects a processor core to an external memory port. The port has a 16-bit address bus and a 24-bit bidirectional data bus, and serves four memory spaces: X data, Y data, program and I/O. The core hands over one access at a time through a request/ready handshake. The block then runs the external read or write cycle. It drives the address and a space code, asserts an active-low read or write strobe, and drives or samples the data bus.

A 16-bit control register holds a wait count for each space. Every strobe lasts at least that count plus one clock. An external wait line, synchronized inside the block, can stretch any strobe for as long as it is held. When another master is granted the bus, the block floats every bus pin and starts no new cycle. During reset all bus pins are floated.

Top module: `xbw_port_ctrl`

## Requirements
- R1: The control register resets to 16'hFFFF and is loaded from `cfg_wdata` on a clock where `cfg_we` is high. Its 4-bit wait fields sit at bits 3:0 for X (space code 0), 7:4 for Y (code 1), 11:8 for program (code 2) and 15:12 for I/O (code 3).
- R2: When the external wait line is low, the strobe of an access stays asserted for exactly W+1 clocks, where W is the wait field of the selected space. `core_rdy` is then high for exactly one clock, in the clock after the last strobe clock.
- R3: A read asserts `bus_rd_n` low. The data bus value on the last strobe clock is returned on `core_rdata` while `core_rdy` is high.
- R4: A write asserts `bus_wr_n` low and drives the core's write data on `bus_data` on every clock of the strobe.
- R5: `bus_rd_n` and `bus_wr_n` are never low at the same time.
- R6: `bus_wait` passes through a two-flop synchronizer. The strobe ends at whichever comes later: the expiry of the wait count, or two clocks after `bus_wait` falls. A wait released after the K-th strobe clock gives a strobe of K+2 clocks.
- R7: During a cycle, `bus_addr` and `bus_space` carry the requested address and space code. While no cycle runs, they hold their last values and do not toggle.
- R8: While `bus_grant` is high, the address, space, data and strobe pins are high-impedance and no new cycle starts. A pending request begins once the grant is released.
- R9: While `rst_n` is low, the address, space, data and strobe pins are high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write value |
| core_req | input | 1 | Core access request, held until ready |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_space | input | 2 | Space code: 0 X, 1 Y, 2 program, 3 I/O |
| core_addr | input | 16 | Access address |
| core_wdata | input | 24 | Write data |
| core_rdata | output | 24 | Read data, valid with ready |
| core_rdy | output | 1 | One-clock completion pulse |
| bus_grant | input | 1 | Bus granted to another master |
| bus_wait | input | 1 | Asynchronous external wait request |
| bus_addr | output | 16 | Tri-state address bus |
| bus_space | output | 2 | Tri-state space code |
| bus_data | inout | 24 | Bidirectional data bus |
| bus_rd_n | output | 1 | Tri-state active-low read strobe |
| bus_wr_n | output | 1 | Tri-state active-low write strobe |

## Verification
A down-counter that loads the wrong field, or misses a decrement, shows up on the first access after the fault as a strobe that is too short or too long. The bench counts strobe clocks, so it detects this within one access. A stuck synchronizer stage or a state that fails to leave the strobe shows as a ready pulse that never comes, and the per-access timeout catches it within a few hundred clocks. A lost capture register shows at once as wrong write data on the pins during the strobe, or as wrong read data at the ready pulse. A fault in an enable shows as a pin that is not pulled high during reset or grant.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_DONE   = 2'd2
    } xbw_state_e;

    localparam int SPACE_X   = 0;
    localparam int SPACE_Y   = 1;
    localparam int SPACE_P   = 2;
    localparam int SPACE_IO  = 3;
endpackage

// File: rtl/xbw_cfg_reg.sv
module xbw_cfg_reg #(
    parameter int NUM_SPACES = 4,
    parameter int WAIT_W     = 4,
    localparam int CFG_W     = NUM_SPACES * WAIT_W,
    localparam int SEL_W     = $clog2(NUM_SPACES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic [SEL_W-1:0]  sel,
    output logic [WAIT_W-1:0] wait_cnt
);
    logic [CFG_W-1:0]  cfg_d, cfg_q;
    logic [WAIT_W-1:0] field [NUM_SPACES];

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '1;
        else        cfg_q <= cfg_d;
    end

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_field
        assign field[s] = cfg_q[s*WAIT_W +: WAIT_W];
    end

    assign wait_cnt = field[sel];

    // R1: a write lands in the register on the following clock
    a_r1_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/xbw_sync.sv
module xbw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
    import xbw_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 24,
    parameter int SPACE_W = 2,
    parameter int WAIT_W  = 4,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_wr,
    input  logic [SPACE_W-1:0] req_space,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  wait_cnt,
    input  logic               grant,
    input  logic               wait_s,
    input  logic [DATA_W-1:0]  bus_in,
    output logic [ADDR_W-1:0]  addr,
    output logic [SPACE_W-1:0] space,
    output logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               rdy
);
    typedef struct packed {
        xbw_state_e         state;
        logic [WAIT_W-1:0]  cnt;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [SPACE_W-1:0] space;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req && !grant) begin
                    r_d.state = ST_STROBE;
                    r_d.cnt   = wait_cnt;
                    r_d.wr    = req_wr;
                    r_d.addr  = req_addr;
                    r_d.space = req_space;
                    r_d.wdata = req_wdata;
                end
            end
            ST_STROBE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (!wait_s) begin
                    if (!r_q.wr) r_d.rdata = bus_in;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, wr: 1'b0, addr: '0,
                     space: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr      = r_q.addr;
    assign space     = r_q.space;
    assign wdata     = r_q.wdata;
    assign rdata     = r_q.rdata;
    assign rd_strobe = (r_q.state == ST_STROBE) && !r_q.wr;
    assign wr_strobe = (r_q.state == ST_STROBE) &&  r_q.wr;
    assign rdy       = (r_q.state == ST_DONE);

    // Checker state: strobe length and the wait count it must reach
    logic [LEN_W-1:0]  len_q;
    logic [WAIT_W-1:0] need_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            need_q <= '0;
        end else if (r_q.state == ST_IDLE && r_d.state == ST_STROBE) begin
            len_q  <= LEN_W'(1);
            need_q <= wait_cnt;
        end else if (r_q.state == ST_STROBE && len_q != '1) begin
            len_q  <= len_q + 1'b1;
        end
    end

    // R2: a strobe never ends before its wait count has run out
    a_r2_min_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STROBE && r_d.state == ST_DONE)
            |-> (len_q >= LEN_W'(need_q) + LEN_W'(1)));

    // R2: ready is a single-clock pulse
    a_r2_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R6: a synchronized wait keeps the strobe going
    a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STROBE && wait_s) |=> (r_q.state == ST_STROBE));

    // R7: address is frozen for the whole strobe
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STROBE && $past(r_q.state) == ST_STROBE)
            |-> $stable(r_q.addr));

    // R8: no cycle begins while the bus is granted away
    a_r8_no_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && grant) |=> (r_q.state == ST_IDLE));
endmodule

// File: rtl/xbw_port_ctrl.sv
module xbw_port_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 24,
    parameter int NUM_SPACES  = 4,
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CFG_W      = NUM_SPACES * WAIT_W,
    localparam int SPACE_W    = $clog2(NUM_SPACES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               core_req,
    input  logic               core_wr,
    input  logic [SPACE_W-1:0] core_space,
    input  logic [ADDR_W-1:0]  core_addr,
    input  logic [DATA_W-1:0]  core_wdata,
    output logic [DATA_W-1:0]  core_rdata,
    output logic               core_rdy,
    input  logic               bus_grant,
    input  logic               bus_wait,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [SPACE_W-1:0] bus_space,
    inout  wire  [DATA_W-1:0]  bus_data,
    output logic               bus_rd_n,
    output logic               bus_wr_n
);
    logic [WAIT_W-1:0]  wait_cnt;
    logic               wait_s;
    logic [ADDR_W-1:0]  addr_q;
    logic [SPACE_W-1:0] space_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               rd_strobe, wr_strobe;
    logic               pins_en, data_en;

    xbw_cfg_reg #(.NUM_SPACES(NUM_SPACES), .WAIT_W(WAIT_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .sel      (core_space),
        .wait_cnt (wait_cnt)
    );

    xbw_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_wait),
        .dout  (wait_s)
    );

    xbw_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPACE_W(SPACE_W), .WAIT_W(WAIT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (core_req),
        .req_wr    (core_wr),
        .req_space (core_space),
        .req_addr  (core_addr),
        .req_wdata (core_wdata),
        .wait_cnt  (wait_cnt),
        .grant     (bus_grant),
        .wait_s    (wait_s),
        .bus_in    (bus_data),
        .addr      (addr_q),
        .space     (space_q),
        .wdata     (wdata_q),
        .rdata     (core_rdata),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .rdy       (core_rdy)
    );

    assign pins_en   = rst_n && !bus_grant;
    assign data_en   = pins_en && wr_strobe;
    assign bus_addr  = pins_en ? addr_q   : 'z;
    assign bus_space = pins_en ? space_q  : 'z;
    assign bus_rd_n  = pins_en ? !rd_strobe : 1'bz;
    assign bus_wr_n  = pins_en ? !wr_strobe : 1'bz;
    assign bus_data  = data_en ? wdata_q  : 'z;

    // R5: the two strobes of the sequencer are mutually exclusive
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // R4: write data stays constant across a write strobe
    a_r4_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && $past(wr_strobe)) |-> $stable(wdata_q));
endmodule

// File: tb/xbw_port_ctrl_tb.sv
module xbw_port_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        core_req = 1'b0;
    logic        core_wr = 1'b0;
    logic [1:0]  core_space = '0;
    logic [15:0] core_addr = '0;
    logic [23:0] core_wdata = '0;
    logic [23:0] core_rdata;
    logic        core_rdy;
    logic        bus_grant = 1'b0;
    logic        bus_wait = 1'b0;
    wire  [15:0] bus_addr;
    wire  [1:0]  bus_space;
    wire  [23:0] bus_data;
    wire         bus_rd_n;
    wire         bus_wr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbw_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .core_req(core_req), .core_wr(core_wr), .core_space(core_space),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_rdy(core_rdy),
        .bus_grant(bus_grant), .bus_wait(bus_wait),
        .bus_addr(bus_addr), .bus_space(bus_space), .bus_data(bus_data),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    // Weak pull-ups: a floating pin reads as all ones
    for (genvar i = 0; i < 24; i++) begin : g_pu_d
        pullup (bus_data[i]);
    end
    for (genvar i = 0; i < 16; i++) begin : g_pu_a
        pullup (bus_addr[i]);
    end
    pullup (bus_space[0]);
    pullup (bus_space[1]);
    pullup (bus_rd_n);
    pullup (bus_wr_n);

    // External memory model: word depends on space and address
    wire [23:0] mem_word = {bus_space, 6'h15, bus_addr};
    assign bus_data = (bus_rd_n == 1'b0) ? mem_word : 'z;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access; release_at >= 0 drops bus_wait after that many strobe clocks
    task automatic run_access(input logic [1:0] sp, input bit wr,
                              input logic [15:0] a, input logic [23:0] wd,
                              input int exp_len, input int release_at);
        int len = 0;
        int guard = 0;
        bit addr_ok = 1'b1;
        bit data_ok = 1'b1;
        bit excl_ok = 1'b1;
        bit rd_seen = 1'b0;
        bit wr_seen = 1'b0;
        @(negedge clk);
        core_req = 1'b1;
        core_wr = wr;
        core_space = sp;
        core_addr = a;
        core_wdata = wd;
        forever begin
            @(negedge clk);
            guard++;
            if (bus_rd_n == 1'b0 && bus_wr_n == 1'b0) excl_ok = 1'b0;
            if (bus_rd_n == 1'b0 || bus_wr_n == 1'b0) begin
                len++;
                if (bus_rd_n == 1'b0) rd_seen = 1'b1;
                if (bus_wr_n == 1'b0) wr_seen = 1'b1;
                if (bus_addr != a || bus_space != sp) addr_ok = 1'b0;
                if (wr && bus_data != wd) data_ok = 1'b0;
                if (release_at >= 0 && len == release_at) bus_wait = 1'b0;
            end
            if (core_rdy || guard > 300) break;
        end
        chk(core_rdy, "R2 ready", 32'(core_rdy), 32'd1);
        chk(len == exp_len, "R2/R6 strobe length", 32'(len), 32'(exp_len));
        chk(excl_ok, "R5 strobe exclusion", 32'(excl_ok), 32'd1);
        chk(addr_ok, "R7 address/space", 32'(bus_addr), 32'(a));
        chk(wr ? (wr_seen && !rd_seen) : (rd_seen && !wr_seen),
            wr ? "R4 write strobe" : "R3 read strobe",
            32'({rd_seen, wr_seen}), wr ? 32'd1 : 32'd2);
        if (wr) chk(data_ok, "R4 write data", 32'(data_ok), 32'd1);
        else    chk(core_rdata == {sp, 6'h15, a}, "R3 read data",
                    32'(core_rdata), 32'({sp, 6'h15, a}));
        core_req = 1'b0;
        @(negedge clk);
        chk(!core_rdy, "R2 ready single pulse", 32'(core_rdy), 32'd0);
    endtask

    typedef struct packed {
        logic [15:0] cfg;
        logic [1:0]  sp;
        logic        wr;
        logic [15:0] addr;
        logic [23:0] wdata;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{cfg: 16'h0000, sp: 2'd0, wr: 1'b0, addr: 16'h1234, wdata: 24'h0},
        '{cfg: 16'h0020, sp: 2'd1, wr: 1'b1, addr: 16'h00AA, wdata: 24'hC0FFEE},
        '{cfg: 16'h0500, sp: 2'd2, wr: 1'b0, addr: 16'hFFFF, wdata: 24'h0},
        '{cfg: 16'hA000, sp: 2'd3, wr: 1'b1, addr: 16'h8001, wdata: 24'h123456},
        '{cfg: 16'h3F70, sp: 2'd0, wr: 1'b0, addr: 16'h0F0F, wdata: 24'h0},
        '{cfg: 16'h1234, sp: 2'd3, wr: 1'b0, addr: 16'h4321, wdata: 24'h0}
    };

    function automatic int field_of(input logic [15:0] c, input logic [1:0] sp);
        return int'(c[sp*4 +: 4]);
    endfunction

    initial begin
        // R9: float during reset
        repeat (3) @(negedge clk);
        chk(bus_addr == 16'hFFFF, "R9 address floats in reset", 32'(bus_addr), 32'hFFFF);
        chk(bus_data == 24'hFFFFFF, "R9 data floats in reset", 32'(bus_data), 32'hFFFFFF);
        chk(bus_space == 2'b11, "R9 space floats in reset", 32'(bus_space), 32'd3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_addr == 16'h0000, "R9 address driven after reset", 32'(bus_addr), 32'h0);
        chk(!core_rdy, "R2 no ready at reset", 32'(core_rdy), 32'd0);

        // R1: reset wait count is 15 in every space
        run_access(2'd2, 1'b0, 16'h0042, 24'h0, 16, -1);

        // Table walk (R1 fields, R2, R3, R4)
        for (int i = 0; i < 6; i++) begin
            set_cfg(VECS[i].cfg);
            run_access(VECS[i].sp, VECS[i].wr, VECS[i].addr, VECS[i].wdata,
                       field_of(VECS[i].cfg, VECS[i].sp) + 1, -1);
        end

        // R7: address holds while idle
        repeat (5) @(negedge clk);
        chk(bus_addr == 16'h4321 && bus_space == 2'd3, "R7 address held idle",
            32'(bus_addr), 32'h4321);

        // R6: external wait stretches past the count (X wait = 1, release after 6)
        set_cfg(16'h0001);
        bus_wait = 1'b1;
        repeat (3) @(negedge clk);
        run_access(2'd0, 1'b1, 16'h0101, 24'hABCDEF, 8, 6);
        // R6: wait shorter than the count has no effect (Y wait = 9)
        set_cfg(16'h0090);
        bus_wait = 1'b1;
        repeat (3) @(negedge clk);
        run_access(2'd1, 1'b0, 16'h0202, 24'h0, 10, 1);

        // R8: grant floats the bus and holds off a pending request
        @(negedge clk);
        bus_grant = 1'b1;
        @(negedge clk);
        chk(bus_addr == 16'hFFFF, "R8 address floats in grant", 32'(bus_addr), 32'hFFFF);
        chk(bus_data == 24'hFFFFFF, "R8 data floats in grant", 32'(bus_data), 32'hFFFFFF);
        core_req = 1'b1;
        core_wr = 1'b1;
        core_space = 2'd0;
        core_addr = 16'h7777;
        core_wdata = 24'h000001;
        repeat (6) @(negedge clk);
        chk(!core_rdy && bus_wr_n == 1'b1 && bus_data == 24'hFFFFFF,
            "R8 no cycle while granted", 32'(core_rdy), 32'd0);
        bus_grant = 1'b0;
        core_req = 1'b0;
        set_cfg(16'h0002);
        run_access(2'd0, 1'b1, 16'h7777, 24'h000001, 3, -1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule